// File: doc/BRIEF.md
# Vector Length Configuration Register

This block holds the active vector length and element type of a vector coprocessor. Each configuration request carries an element width, a register-group multiplier, an application vector length and two flags telling whether the destination and source register fields name x0. The block works out the maximum element count the register group can hold, grants a length, stores it and reports it on a result port one cycle after the request.

The length is kept in a compact form: a byte count minus one, plus a separate flag meaning "the length is zero". Downstream execution units use the byte form directly. The element count is recovered by shifting the byte count right by the element size. A request with both register fields at x0 keeps the current element count and changes only the type. In that case the byte form is rebuilt for the new element width. The register length in bytes is a fixed parameter.

Top module: `vl_cfg_reg`

## Requirements
- R1: After a synchronous active-low reset, `len_zero` is 1, and `len_bytes_m1`, `cur_sew`, `cur_lmul`, `vl_res` and `res_valid` are 0.
- R2: For a granted length G > 0, `len_bytes_m1` holds G times the element byte size, minus one, and `len_zero` is 0. For example, 3 elements at 16-bit width store 5.
- R3: A granted length of 0 sets `len_zero` to 1 and stores 0 in `len_bytes_m1`.
- R4: When `rs1_x0` is 0, the granted length is min(`avl`, VLMAX). VLMAX = `VLEN_BYTES` * 2^`lmul` / 2^sew.
- R5: When `rs1_x0` is 1 and `rd_x0` is 0, the granted length is VLMAX.
- R6: When both `rd_x0` and `rs1_x0` are 1, the current element count is kept, the type fields update, the byte form is recomputed for the new width, and `len_zero` is not set for a nonzero count. For example, 11 elements at e16/m2 followed by this form at e8/m1 give 11 elements and `len_bytes_m1` = 10.
- R7: In the keep-length form, a kept count above the new VLMAX is reduced to VLMAX, and a current length of zero stays zero.
- R8: Every request loads `cur_lmul` from `lmul` and `cur_sew` from `sew`. Encoding for `sew`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 is stored and treated as 2. Encoding for `lmul`: 0..3 = multiplier 1, 2, 4, 8.
- R9: The granted element count appears on `vl_res` with a one-cycle `res_valid` pulse in the cycle after `req_valid`. Without a request, the stored length and type do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Configuration request strobe |
| sew | input | 2 | Requested element width code |
| lmul | input | 2 | Requested register-group multiplier, log2 |
| avl | input | AVL_W | Application vector length in elements |
| rd_x0 | input | 1 | Destination register field is x0 |
| rs1_x0 | input | 1 | Source register field is x0 |
| len_bytes_m1 | output | BYTE_W | Stored length in bytes minus one |
| len_zero | output | 1 | Stored length is zero |
| cur_sew | output | 2 | Current element width code |
| cur_lmul | output | 2 | Current multiplier code |
| vl_res | output | ELEM_W | Granted length in elements |
| res_valid | output | 1 | `vl_res` is valid this cycle |

## Verification
The bench builds the block with `VLEN_BYTES` = 16 and `AVL_W` = 16, so VLMAX ranges from 4 (e32/m1) to 128 (e8/m8). Random requested lengths up to 199 therefore land below, at and above VLMAX for every type, and requests of zero produce the zero flag. A 16-byte register lets a keep-length request move to a wider element so the kept count exceeds the new VLMAX. It also lets the full byte range up to 127 be exercised.

// File: rtl/vl_cfg_pkg.sv
// Shared helpers for the vector length configuration register.
// Assumes element width codes 0..2 (8/16/32 bits); code 3 is folded onto 2.
package vl_cfg_pkg;
    // Map a requested width code onto a supported one.
    function automatic logic [1:0] norm_sew(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction
endpackage

// File: rtl/vl_grant_calc.sv
// Computes the maximum element count for a type and the granted length.
// Assumes AVL_W >= ELEM_W and that sew_n is already normalised.
module vl_grant_calc #(
    parameter int VLEN_BYTES = 16,
    parameter int AVL_W      = 32,
    parameter int ELEM_W     = 8
) (
    input  logic [1:0]        sew_n,
    input  logic [1:0]        lmul,
    input  logic [AVL_W-1:0]  avl,
    input  logic [ELEM_W-1:0] cur_vl,
    input  logic              rd_x0,
    input  logic              rs1_x0,
    output logic [ELEM_W-1:0] vlmax,
    output logic [ELEM_W-1:0] grant
);
    localparam logic [ELEM_W-1:0] BASE = ELEM_W'(VLEN_BYTES);

    // Register-group capacity in elements of the requested width.
    always_comb vlmax = (BASE << lmul) >> sew_n;

    // Pick the granted length from the three request forms.
    always_comb begin
        if (!rs1_x0) begin
            grant = (avl < AVL_W'(vlmax)) ? ELEM_W'(avl) : vlmax;
        end else if (!rd_x0) begin
            grant = vlmax;
        end else begin
            grant = (cur_vl < vlmax) ? cur_vl : vlmax;
        end
    end
endmodule

// File: rtl/vl_byte_encode.sv
// Converts an element count into the byte-count-minus-one form plus zero flag.
// Assumes count << sew_n fits ELEM_W bits (guaranteed by the VLMAX clamp).
module vl_byte_encode #(
    parameter int ELEM_W = 8,
    parameter int BYTE_W = 7
) (
    input  logic [ELEM_W-1:0] count,
    input  logic [1:0]        sew_n,
    output logic [BYTE_W-1:0] bytes_m1,
    output logic              zero
);
    logic [ELEM_W-1:0] nbytes;

    // Scale elements to bytes, then apply the minus-one encoding.
    always_comb begin
        nbytes   = count << sew_n;
        zero     = (count == '0);
        bytes_m1 = zero ? '0 : BYTE_W'(nbytes - ELEM_W'(1));
    end
endmodule

// File: rtl/vl_cfg_reg.sv
// Vector length configuration register: grants and stores the active length
// in byte-minus-one form with a zero flag, plus the element type.
// Assumes a single request per cycle; result appears one cycle later.
module vl_cfg_reg #(
    parameter int VLEN_BYTES = 16,
    parameter int AVL_W      = 32,
    parameter int ELEM_W     = $clog2(VLEN_BYTES * 8 + 1),
    parameter int BYTE_W     = $clog2(VLEN_BYTES * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        sew,
    input  logic [1:0]        lmul,
    input  logic [AVL_W-1:0]  avl,
    input  logic              rd_x0,
    input  logic              rs1_x0,
    output logic [BYTE_W-1:0] len_bytes_m1,
    output logic              len_zero,
    output logic [1:0]        cur_sew,
    output logic [1:0]        cur_lmul,
    output logic [ELEM_W-1:0] vl_res,
    output logic              res_valid
);
    import vl_cfg_pkg::*;

    logic [1:0]        sew_n;
    logic [ELEM_W-1:0] cur_vl;
    logic [ELEM_W-1:0] vlmax_w;
    logic [ELEM_W-1:0] grant_w;
    logic [BYTE_W-1:0] enc_bytes;
    logic              enc_zero;

    // Normalise the requested width code.
    always_comb sew_n = norm_sew(sew);

    // Recover the current element count from the stored byte form.
    always_comb cur_vl = len_zero ? '0
                       : ELEM_W'((ELEM_W'(len_bytes_m1) + ELEM_W'(1)) >> cur_sew);

    vl_grant_calc #(.VLEN_BYTES(VLEN_BYTES), .AVL_W(AVL_W), .ELEM_W(ELEM_W)) calc_i (
        .sew_n(sew_n), .lmul(lmul), .avl(avl), .cur_vl(cur_vl),
        .rd_x0(rd_x0), .rs1_x0(rs1_x0), .vlmax(vlmax_w), .grant(grant_w)
    );

    vl_byte_encode #(.ELEM_W(ELEM_W), .BYTE_W(BYTE_W)) enc_i (
        .count(grant_w), .sew_n(sew_n), .bytes_m1(enc_bytes), .zero(enc_zero)
    );

    // Load the new configuration and result on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_bytes_m1 <= '0;
            len_zero     <= 1'b1;
            cur_sew      <= '0;
            cur_lmul     <= '0;
            vl_res       <= '0;
            res_valid    <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                len_bytes_m1 <= enc_bytes;
                len_zero     <= enc_zero;
                cur_sew      <= sew_n;
                cur_lmul     <= lmul;
                vl_res       <= grant_w;
            end
        end
    end

    // R3
    zero_clears_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_zero |-> (len_bytes_m1 == '0));

    // R9
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R9
    idle_holds_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(len_bytes_m1) && $stable(len_zero) && !res_valid));

    // R6
    keep_form_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_x0 && rs1_x0 && !len_zero && (cur_vl <= vlmax_w))
        |=> ((vl_res == $past(cur_vl)) && !len_zero));

    // R4
    grant_within_vlmax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (vl_res <= ((ELEM_W'(VLEN_BYTES) << cur_lmul) >> cur_sew)));

    // R2
    bytes_match_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !len_zero) |-> (cur_vl == vl_res));
endmodule

// File: tb/vl_cfg_reg_tb_top.sv
module vl_cfg_reg_tb_top;
    localparam int VB = 16;
    localparam int AW = 16;
    localparam int EW = $clog2(VB * 8 + 1);
    localparam int BW = $clog2(VB * 8);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    sew = '0, lmul = '0;
    logic [AW-1:0] avl = '0;
    logic          rd_x0 = 1'b0, rs1_x0 = 1'b0;
    logic [BW-1:0] len_bytes_m1;
    logic          len_zero;
    logic [1:0]    cur_sew, cur_lmul;
    logic [EW-1:0] vl_res;
    logic          res_valid;

    int n_chk = 0, n_fail = 0;
    int m_vl = 0, m_sew = 0, m_lmul = 0;

    always #10 clk = ~clk;

    vl_cfg_reg #(.VLEN_BYTES(VB), .AVL_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sew(sew), .lmul(lmul),
        .avl(avl), .rd_x0(rd_x0), .rs1_x0(rs1_x0), .len_bytes_m1(len_bytes_m1),
        .len_zero(len_zero), .cur_sew(cur_sew), .cur_lmul(cur_lmul),
        .vl_res(vl_res), .res_valid(res_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int vlmax_of(input int s, input int l);
        return (VB << l) >> s;
    endfunction

    // Issue one request, update the model, and check the registered outputs.
    task automatic do_req(input int s, input int l, input int a, input bit d0,
                          input bit s0, input string req);
        int se, vm, g;
        se = (s == 3) ? 2 : s;
        vm = vlmax_of(se, l);
        if (!s0)      g = (a < vm) ? a : vm;
        else if (!d0) g = vm;
        else          g = (m_vl < vm) ? m_vl : vm;
        @(negedge clk);
        req_valid = 1'b1; sew = 2'(s); lmul = 2'(l); avl = AW'(a);
        rd_x0 = d0; rs1_x0 = s0;
        @(negedge clk);
        req_valid = 1'b0;
        m_vl = g; m_sew = se; m_lmul = l;
        check({req, " vl_res"}, int'(vl_res), g);
        check({req, " R9 res_valid"}, int'(res_valid), 1);
        check({req, " R3 len_zero"}, int'(len_zero), (g == 0) ? 1 : 0);
        check({req, " R2 len_bytes_m1"}, int'(len_bytes_m1), (g == 0) ? 0 : (g << se) - 1);
        check({req, " R8 cur_sew"}, int'(cur_sew), se);
        check({req, " R8 cur_lmul"}, int'(cur_lmul), l);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        process::self().srandom(32'd7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 len_zero", int'(len_zero), 1);
        check("R1 len_bytes_m1", int'(len_bytes_m1), 0);
        check("R1 cur_sew", int'(cur_sew), 0);
        check("R1 cur_lmul", int'(cur_lmul), 0);
        check("R1 vl_res", int'(vl_res), 0);
        check("R1 res_valid", int'(res_valid), 0);
        // R7 keep form from zero length stays zero
        do_req(0, 0, 0, 1, 1, "R7 keep-from-zero");
        // R2 3 elements at e16 store 5
        do_req(1, 0, 3, 0, 0, "R2 e16x3");
        // R3 zero request
        do_req(0, 1, 0, 0, 0, "R3 avl0");
        // R6 11 at e16/m2 then keep at e8/m1
        do_req(1, 1, 11, 0, 0, "R4 e16m2x11");
        do_req(0, 0, 99, 1, 1, "R6 keep e8m1");
        check("R6 bytes 11", int'(len_bytes_m1), 10);
        // R9 idle cycle leaves state untouched
        @(negedge clk);
        check("R9 idle res_valid", int'(res_valid), 0);
        check("R9 idle bytes", int'(len_bytes_m1), 10);
        check("R9 idle zero", int'(len_zero), 0);
        // R5 vlmax form
        do_req(0, 3, 5, 0, 1, "R5 e8m8");
        check("R5 vlmax 128", int'(vl_res), 128);
        // R7 keep to wider width clamps
        do_req(2, 0, 0, 1, 1, "R7 keep clamp e32m1");
        check("R7 clamp 4", int'(vl_res), 4);
        // R4 above vlmax clamps, R8 code 3
        do_req(3, 1, 500, 0, 0, "R4 R8 sew3");
        // Random mix of all forms
        for (int i = 0; i < 300; i++) begin
            int f;
            f = int'($urandom_range(0, 5));
            do_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 199)), (f == 4 || f == 5), (f >= 3),
                   "R4 R5 R6 R7 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule